// File: doc/BRIEF.md
# Multi-Slot Cipher Key and IV Table

This block keeps the key material for a block-cipher datapath in a small set of numbered slots. Every slot holds a key of up to 256 bits, the initialisation vector as first loaded (the "original" IV), and a running "updated" IV that the datapath refreshes after each chained block. A slot is filled by a table-load request: the requester names the slot and key length, then streams sixteen 32-bit words from an internal RAM port, one word per cycle in which the word-valid strobe is high.

The datapath picks the active slot with a slot-index input and, per operation, picks which of the two IVs it wants. The block presents the active slot's key (with the unused tail forced to zero), its key-length code, the chosen IV and a flag saying whether that IV holds meaningful data. After each chained block the datapath writes the new IV back into the active slot. One slot carries a secure key that is set at reset and cannot be replaced through the load path.

Top module: `kslot_table`

## Requirements
- R1: A load is started by `ld_start` with `ld_table_id` = {1'b1, slot}; `ld_busy` is high from the next cycle until the 16th accepted word, word k of the stream (k = 0..15) lands in slot word k, and `ld_done` pulses for one cycle in the cycle after the 16th word is accepted.
- R2: `ld_key_len` codes are 0 = 128, 1 = 192, 2 = 256 bits; slot words 0..7 form the key with word 0 in bits [255:224]; `key_out` shows only the first 4, 6 or 8 words and zeros the rest; code 3 is rejected with `ld_err` and changes nothing.
- R3: Slot 4 is the secure slot: after reset it holds the `SECURE_KEY` parameter with length code 2, a zero original IV and reports its original IV as valid; a load naming slot 4 pulses `ld_err` the cycle after `ld_start`, never asserts `ld_busy` and leaves the slot unchanged.
- R4: A load whose table-id flag bit (bit 3) is 0 is rejected with `ld_err` and changes no slot.
- R5: With `iv_sel` = 0, `iv_out` is the original IV (slot words 8..11); with `iv_sel` = 1 it is the updated IV (slot words 12..15); the lower word index is in the upper bits.
- R6: `iv_valid` for the original IV is 1 once the slot has completed a load; for the updated IV it is 0 after a completed load and becomes 1 only after a write-back to that slot.
- R7: A pulse of `iv_wb_en` stores `iv_wb_data` as the active slot's updated IV at the next edge; a write-back while `ld_busy` is high is ignored.
- R8: `sel_slot` becomes the active slot (`act_slot`) one cycle after it is applied, except while `ld_busy` is high, when the active slot is held and the pending choice takes effect the cycle after the load ends.
- R9: `ld_start` while a load is in progress is ignored: it neither redirects the running load nor starts a new one.
- R10: After reset, the active slot is 0, `ld_busy`, `ld_done`, `ld_err` are 0, and non-secure slots read back zero key and report no valid IV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_start | input | 1 | Start a table load |
| ld_table_id | input | 4 | Flag bit 3 set, slot number in bits 2:0 |
| ld_key_len | input | 2 | Key length code for the load |
| ld_word_vld | input | 1 | A load word is present |
| ld_word | input | 32 | Load word from the RAM port |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | Load completed (one-cycle pulse) |
| ld_err | output | 1 | Load request rejected (one-cycle pulse) |
| sel_slot | input | 3 | Requested active slot |
| iv_sel | input | 1 | 0 original IV, 1 updated IV |
| iv_wb_en | input | 1 | Write back the updated IV |
| iv_wb_data | input | 128 | Updated IV value |
| act_slot | output | 3 | Slot currently driving the outputs |
| key_out | output | 256 | Active key, unused tail zeroed |
| key_len_out | output | 2 | Active key length code |
| iv_out | output | 128 | Selected IV of the active slot |
| iv_valid | output | 1 | Selected IV holds meaningful data |

## Verification
The hardest situation to reach is a load in flight while other requests arrive at once: a slot change, a second start aimed at another slot and an IV write-back all land during the sixteen-word stream. The bench raises all three in the first streamed cycle of a load, then checks that the active slot stayed put, that the write-back target still shows its earlier IV, that the second target never became loaded, and that the held slot choice is applied exactly one cycle after the load ends.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SLOT_WORDS = 16;
  localparam int unsigned KEY_WORDS = 8;
  localparam int unsigned IV_WORDS  = 4;
  localparam int unsigned KEY_BITS  = KEY_WORDS * WORD_W;
  localparam int unsigned IV_BITS   = IV_WORDS * WORD_W;
  localparam int unsigned SLOT_BITS = SLOT_WORDS * WORD_W;
  localparam int unsigned IDX_W     = $clog2(SLOT_WORDS);

  typedef enum logic [1:0] {
    KL_128 = 2'd0,
    KL_192 = 2'd1,
    KL_256 = 2'd2,
    KL_BAD = 2'd3
  } klen_e;

  // Clear the key bits that lie past the selected length.
  function automatic logic [KEY_BITS-1:0] key_mask(input logic [KEY_BITS-1:0] k,
                                                   input logic [1:0] len);
    logic [KEY_BITS-1:0] m;
    case (len)
      KL_128:  m = {{128{1'b1}}, {(KEY_BITS-128){1'b0}}};
      KL_192:  m = {{192{1'b1}}, {(KEY_BITS-192){1'b0}}};
      default: m = '1;
    endcase
    return k & m;
  endfunction
endpackage

// File: rtl/kslot_load_ctrl.sv
module kslot_load_ctrl
  import kslot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned SECURE_SLOT = 4,
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic [SLOT_W:0]   ld_table_id,
  input  logic [1:0]        ld_key_len,
  input  logic              ld_word_vld,
  input  logic [WORD_W-1:0] ld_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              commit,
  output logic [1:0]        commit_len
);
  logic              start_ok, start_bad;
  logic [SLOT_W-1:0] req_slot;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        len_q;

  assign req_slot  = ld_table_id[SLOT_W-1:0];
  assign start_ok  = ld_start && !busy && ld_table_id[SLOT_W] &&
                     (req_slot != SLOT_W'(SECURE_SLOT)) && (ld_key_len != KL_BAD);
  assign start_bad = ld_start && !busy && !start_ok;

  assign wr_en      = busy && ld_word_vld;
  assign wr_slot    = slot_q;
  assign wr_idx     = idx_q;
  assign wr_data    = ld_word;
  assign commit     = wr_en && (idx_q == IDX_W'(SLOT_WORDS-1));
  assign commit_len = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      slot_q <= '0;
      idx_q  <= '0;
      len_q  <= KL_128;
    end else begin
      done <= commit;
      err  <= start_bad;
      if (start_ok) begin
        busy   <= 1'b1;
        slot_q <= req_slot;
        len_q  <= ld_key_len;
        idx_q  <= '0;
      end else if (wr_en) begin
        idx_q <= idx_q + 1'b1;
        if (commit) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kslot_store.sv
module kslot_store
  import kslot_pkg::*;
#(
  parameter int unsigned     NUM_SLOTS   = 8,
  parameter int unsigned     SECURE_SLOT = 4,
  parameter logic [255:0]    SECURE_KEY  = '0,
  localparam int unsigned    SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              commit,
  input  logic [1:0]        commit_len,
  input  logic              wb_en,
  input  logic [SLOT_W-1:0] wb_slot,
  input  logic [IV_BITS-1:0] wb_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SLOT_BITS-1:0] rd_bits,
  output logic [1:0]        rd_len,
  output logic              rd_loaded,
  output logic              rd_upd_ok
);
  logic [SLOT_BITS-1:0] slot_flat [NUM_SLOTS];
  logic [1:0]           slot_len  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] loaded_v, upd_ok_v;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] w_q [SLOT_WORDS];
    logic              ld_q, ok_q;
    logic [1:0]        len_q;
    logic              hit_wr, hit_wb;

    assign hit_wr = wr_en && (wr_slot == SLOT_W'(s));
    assign hit_wb = wb_en && (wb_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < SLOT_WORDS; w++)
          w_q[w] <= (s == SECURE_SLOT && w < KEY_WORDS) ?
                    SECURE_KEY[KEY_BITS-1-WORD_W*w -: WORD_W] : '0;
        ld_q  <= (s == SECURE_SLOT);
        len_q <= (s == SECURE_SLOT) ? KL_256 : KL_128;
        ok_q  <= 1'b0;
      end else begin
        if (hit_wr) w_q[wr_idx] <= wr_data;
        if (hit_wb)
          for (int w = 0; w < IV_WORDS; w++)
            w_q[KEY_WORDS+IV_WORDS+w] <= wb_data[IV_BITS-1-WORD_W*w -: WORD_W];
        if (hit_wr && commit) begin
          ld_q  <= 1'b1;
          len_q <= commit_len;
          ok_q  <= 1'b0;
        end else if (hit_wb) begin
          ok_q <= 1'b1;
        end
      end
    end

    for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_flat
      assign slot_flat[s][SLOT_BITS-1-WORD_W*w -: WORD_W] = w_q[w];
    end
    assign slot_len[s]  = len_q;
    assign loaded_v[s]  = ld_q;
    assign upd_ok_v[s]  = ok_q;
  end

  assign rd_bits   = slot_flat[rd_slot];
  assign rd_len    = slot_len[rd_slot];
  assign rd_loaded = loaded_v[rd_slot];
  assign rd_upd_ok = upd_ok_v[rd_slot];
endmodule

// File: rtl/kslot_table.sv
module kslot_table
  import kslot_pkg::*;
#(
  parameter int unsigned  NUM_SLOTS   = 8,
  parameter int unsigned  SECURE_SLOT = 4,
  parameter logic [255:0] SECURE_KEY  = {8{32'h5EC0_1234}},
  localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_start,
  input  logic [SLOT_W:0]     ld_table_id,
  input  logic [1:0]          ld_key_len,
  input  logic                ld_word_vld,
  input  logic [WORD_W-1:0]   ld_word,
  output logic                ld_busy,
  output logic                ld_done,
  output logic                ld_err,
  input  logic [SLOT_W-1:0]   sel_slot,
  input  logic                iv_sel,
  input  logic                iv_wb_en,
  input  logic [IV_BITS-1:0]  iv_wb_data,
  output logic [SLOT_W-1:0]   act_slot,
  output logic [KEY_BITS-1:0] key_out,
  output logic [1:0]          key_len_out,
  output logic [IV_BITS-1:0]  iv_out,
  output logic                iv_valid
);
  // internal events, named for the checker
  logic              wr_en, commit, wb_go;
  logic [SLOT_W-1:0] wr_slot;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;
  logic [1:0]        commit_len;
  logic [SLOT_BITS-1:0] rd_bits;
  logic              rd_loaded, rd_upd_ok;
  logic [SLOT_W-1:0] act_q;

  kslot_load_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SECURE_SLOT(SECURE_SLOT)) u_ctrl (
    .clk, .rst_n, .ld_start, .ld_table_id, .ld_key_len, .ld_word_vld, .ld_word,
    .busy(ld_busy), .done(ld_done), .err(ld_err),
    .wr_en, .wr_slot, .wr_idx, .wr_data, .commit, .commit_len);

  assign wb_go = iv_wb_en && !ld_busy;

  kslot_store #(.NUM_SLOTS(NUM_SLOTS), .SECURE_SLOT(SECURE_SLOT),
                .SECURE_KEY(SECURE_KEY)) u_store (
    .clk, .rst_n, .wr_en, .wr_slot, .wr_idx, .wr_data, .commit, .commit_len,
    .wb_en(wb_go), .wb_slot(act_q), .wb_data(iv_wb_data),
    .rd_slot(act_q), .rd_bits, .rd_len(key_len_out),
    .rd_loaded, .rd_upd_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (!ld_busy) act_q <= sel_slot;
  end

  assign act_slot = act_q;
  assign key_out  = key_mask(rd_bits[SLOT_BITS-1 -: KEY_BITS], key_len_out);
  assign iv_out   = iv_sel ? rd_bits[IV_BITS-1:0]
                           : rd_bits[IV_BITS +: IV_BITS];
  assign iv_valid = iv_sel ? rd_upd_ok : rd_loaded;
endmodule

// File: rtl/kslot_chk.sv
module kslot_chk #(
  parameter int unsigned SECURE_SLOT = 4,
  parameter int unsigned SLOT_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_busy,
  input logic              ld_done,
  input logic              ld_err,
  input logic              wr_en,
  input logic [SLOT_W-1:0] wr_slot,
  input logic [SLOT_W-1:0] act_slot,
  input logic [255:0]      key_out,
  input logic [1:0]        key_len_out
);
  // R3
  secure_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_slot != SLOT_W'(SECURE_SLOT));
  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |=> $stable(act_slot));
  // R1
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> ($past(ld_busy) && !ld_busy));
  // R2
  key_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_len_out == 2'd0) |-> (key_out[127:0] == '0));
  // R4
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> (!ld_busy && !ld_done));
endmodule

bind kslot_table kslot_chk #(.SECURE_SLOT(SECURE_SLOT), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_busy(ld_busy), .ld_done(ld_done),
  .ld_err(ld_err), .wr_en(wr_en), .wr_slot(wr_slot), .act_slot(act_slot),
  .key_out(key_out), .key_len_out(key_len_out));

// File: tb/kslot_table_test.sv
module kslot_table_test;
  localparam logic [255:0] SKEY = {32'hC001_0001, 32'hC001_0002, 32'hC001_0003,
                                   32'hC001_0004, 32'hC001_0005, 32'hC001_0006,
                                   32'hC001_0007, 32'hC001_0008};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_start = 0, ld_word_vld = 0, iv_sel = 0, iv_wb_en = 0;
  logic [3:0] ld_table_id = '0;
  logic [1:0] ld_key_len = '0;
  logic [31:0] ld_word = '0;
  logic [2:0] sel_slot = '0;
  logic [127:0] iv_wb_data = '0;
  logic ld_busy, ld_done, ld_err, iv_valid;
  logic [2:0] act_slot;
  logic [255:0] key_out;
  logic [1:0] key_len_out;
  logic [127:0] iv_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  kslot_table #(.SECURE_KEY(SKEY)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] wval(input int slot, input int i);
    return 32'hA000_0000 + 32'(slot) * 32'h0001_0000 + 32'(i) + 32'd1;
  endfunction

  function automatic logic [255:0] exp_key(input int slot, input int len);
    logic [255:0] k = '0;
    int n = (len == 0) ? 4 : (len == 1) ? 6 : 8;
    for (int i = 0; i < n; i++) k[255-32*i -: 32] = wval(slot, i);
    return k;
  endfunction

  function automatic logic [127:0] exp_iv(input int slot, input int first);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[127-32*i -: 32] = wval(slot, first + i);
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pick(input int slot, input bit ivs);
    sel_slot = 3'(slot); iv_sel = ivs;
    @(negedge clk);
  endtask

  task automatic load_slot(input int slot, input int len);
    ld_start = 1; ld_table_id = 4'(8 | slot); ld_key_len = 2'(len);
    @(negedge clk);
    ld_start = 0;
    check("R1 busy after start", 256'(ld_busy), 256'(1));
    for (int i = 0; i < 16; i++) begin
      ld_word_vld = 1; ld_word = wval(slot, i);
      @(negedge clk);
    end
    ld_word_vld = 0;
    check("R1 done pulse", 256'({ld_done, ld_busy}), 256'(2'b10));
    @(negedge clk);
    check("R1 done one cycle", 256'(ld_done), 256'(0));
  endtask

  task automatic t_reset;
    check("R10 reset act", 256'(act_slot), 256'(0));
    check("R10 reset flags", 256'({ld_busy, ld_done, ld_err}), 256'(0));
    check("R10 reset key", key_out, 256'(0));
    check("R10 reset iv_valid", 256'(iv_valid), 256'(0));
  endtask

  task automatic t_load128_and_iv;
    load_slot(1, 0);
    pick(1, 0);
    check("R2 key 128 masked", key_out, exp_key(1, 0));
    check("R2 len code", 256'(key_len_out), 256'(0));
    check("R5 orig iv", 256'(iv_out), 256'(exp_iv(1, 8)));
    check("R6 orig valid", 256'(iv_valid), 256'(1));
    pick(1, 1);
    check("R5 upd iv", 256'(iv_out), 256'(exp_iv(1, 12)));
    check("R6 upd invalid after load", 256'(iv_valid), 256'(0));
    iv_wb_en = 1; iv_wb_data = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    @(negedge clk);
    iv_wb_en = 0;
    check("R7 wb stored", 256'(iv_out), 256'(128'h1111_2222_3333_4444_5555_6666_7777_8888));
    check("R6 upd valid after wb", 256'(iv_valid), 256'(1));
    pick(1, 0);
    check("R7 orig untouched by wb", 256'(iv_out), 256'(exp_iv(1, 8)));
  endtask

  task automatic t_lengths;
    load_slot(2, 2);
    load_slot(7, 1);
    pick(2, 0);
    check("R2 key 256", key_out, exp_key(2, 2));
    pick(7, 0);
    check("R2 key 192", key_out, exp_key(7, 1));
    check("R2 len code 192", 256'(key_len_out), 256'(1));
    ld_start = 1; ld_table_id = 4'(8 | 6); ld_key_len = 2'd3;
    @(negedge clk);
    ld_start = 0;
    check("R2 bad length err", 256'({ld_err, ld_busy}), 256'(2'b10));
    pick(6, 0);
    check("R2 bad length no load", 256'({iv_valid, key_out}), 256'(0));
  endtask

  task automatic t_secure;
    ld_start = 1; ld_table_id = 4'(8 | 4); ld_key_len = 2'd0;
    @(negedge clk);
    ld_start = 0;
    check("R3 secure err", 256'({ld_err, ld_busy}), 256'(2'b10));
    for (int i = 0; i < 16; i++) begin
      ld_word_vld = 1; ld_word = 32'hDEAD_0000 + 32'(i);
      @(negedge clk);
    end
    ld_word_vld = 0;
    pick(4, 0);
    check("R3 secure key kept", key_out, SKEY);
    check("R3 secure len", 256'(key_len_out), 256'(2));
    check("R3 secure iv", 256'({iv_valid, iv_out}), 256'({1'b1, 128'h0}));
  endtask

  task automatic t_bad_id;
    ld_start = 1; ld_table_id = 4'd1; ld_key_len = 2'd2;
    @(negedge clk);
    ld_start = 0;
    check("R4 flag bit clear err", 256'({ld_err, ld_busy}), 256'(2'b10));
    for (int i = 0; i < 16; i++) begin
      ld_word_vld = 1; ld_word = 32'hBAD0_0000 + 32'(i);
      @(negedge clk);
    end
    ld_word_vld = 0;
    pick(1, 0);
    check("R4 slot 1 unchanged", key_out, exp_key(1, 0));
  endtask

  task automatic t_busy_overlap;
    pick(1, 0);
    ld_start = 1; ld_table_id = 4'(8 | 3); ld_key_len = 2'd2;
    @(negedge clk);
    ld_start = 1; ld_table_id = 4'(8 | 5); sel_slot = 3'd5;
    iv_wb_en = 1; iv_wb_data = 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000;
    for (int i = 0; i < 16; i++) begin
      ld_word_vld = 1; ld_word = wval(3, i);
      @(negedge clk);
      ld_start = 0; iv_wb_en = 0;
      if (i == 0) check("R8 act held during load", 256'(act_slot), 256'(1));
    end
    ld_word_vld = 0;
    check("R8 act held at done", 256'({ld_done, act_slot}), 256'({1'b1, 3'd1}));
    @(negedge clk);
    check("R8 pending select applied", 256'(act_slot), 256'(5));
    check("R9 second start ignored", 256'({iv_valid, ld_busy}), 256'(0));
    pick(3, 0);
    check("R1 slot 3 key", key_out, exp_key(3, 2));
    pick(1, 1);
    check("R7 wb during load ignored", 256'(iv_out),
          256'(128'h1111_2222_3333_4444_5555_6666_7777_8888));
  endtask

  task automatic t_reload;
    load_slot(1, 2);
    pick(1, 1);
    check("R6 reload clears upd valid", 256'({iv_valid, iv_out}), 256'({1'b0, exp_iv(1, 12)}));
    check("R1 reload key", key_out, exp_key(1, 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load128_and_iv();
    t_lengths();
    t_secure();
    t_bad_id();
    t_busy_overlap();
    t_reload();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule